// File: doc/BRIEF.md
# I2C Interrupt Flag and Vector Unit

This block gathers the event pulses of an I2C protocol engine into six sticky interrupt flags. The events are arbitration lost, NACK received, START detected, STOP detected, receive character complete and transmit buffer emptied. Each flag has its own enable bit. The enabled flags are combined into a single interrupt request, and a fixed six-level priority encoder turns them into an even-numbered vector code that software reads to find the most urgent source.

Flags clear on several conditions:
- the buffer access that services them: a receive-buffer read clears the receive flag, and a transmit-buffer write clears the transmit flag;
- protocol events: a START clears the NACK and STOP flags, and a STOP clears the START flag;
- a read of the vector register, which clears the source it reports.

Software reaches the unit through a small register port with a two-bit select. Select 0 is the enable register, 1 is the flag register and 2 is the vector register. Read data is combinational on the select.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: The flag register (select 1) holds receive at bit 0, transmit at bit 1, START at bit 2, STOP at bit 3, arbitration lost at bit 4 and NACK at bit 5. Bits 7:6 always read as 0.
- R2: The enable register (select 0) uses the same bit positions as the flag register, resets to 0, and reads 0 in bits 7:6.
- R3: After reset the flag register reads 02h: only the transmit flag is set.
- R4: A receive-complete pulse sets the receive flag on the next clock edge, and a receive-buffer read pulse clears it.
- R5: A transmit-buffer write pulse clears the transmit flag, and a transmit-empty pulse sets it.
- R6: A START pulse clears the NACK flag and the STOP flag.
- R7: A STOP pulse clears the START flag.
- R8: With every source enabled, the vector (select 2) reads 00h when nothing is pending. Otherwise it reports the highest pending source, using 02h for arbitration lost, 04h for NACK, 06h for START, 08h for STOP, 0Ah for receive and 0Ch for transmit, in that priority order.
- R9: Only flags whose enable bit is set take part in the vector and in the interrupt request, and `irq` is high exactly when the vector is non-zero.
- R10: A read strobe on the vector register clears the one flag it reports in that cycle, so the next read reports the next pending source. A read of 00h clears nothing.
- R11: When a set event and a clear event reach the same flag in the same cycle, the flag ends up set.
- R12: A software write to the flag register sets or clears each flag to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | NACK received pulse |
| ev_start | input | 1 | START detected pulse |
| ev_stop | input | 1 | STOP detected pulse |
| ev_rx_done | input | 1 | Receive character complete pulse |
| ev_tx_empty | input | 1 | Transmit buffer emptied pulse |
| rxbuf_rd | input | 1 | Software read of the receive buffer |
| txbuf_wr | input | 1 | Software write of the transmit buffer |
| reg_sel | input | 2 | Register select: 0 enable, 1 flags, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumed by the vector register) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are the collisions: a set and a clear hitting one flag in the same cycle, and START and STOP arriving together. With only single pulses these never occur. The bench therefore drives both pulses in one cycle and reads the flag register afterwards. The full priority chain is also awkward to reach through protocol events alone. The bench writes all six flags at once through the flag register and then drains them with successive vector reads, which checks every code and its order.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_FLAGS = 6;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 2;

  localparam int F_RX    = 0;
  localparam int F_TX    = 1;
  localparam int F_START = 2;
  localparam int F_STOP  = 3;
  localparam int F_ARB   = 4;
  localparam int F_NACK  = 5;

  localparam logic [SEL_W-1:0] SEL_EN   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_FLAG = 2'd1;
  localparam logic [SEL_W-1:0] SEL_VEC  = 2'd2;

  localparam logic [NUM_FLAGS-1:0] FLAG_RESET = NUM_FLAGS'(1) << F_TX;

  // Flag index that owns a priority rank (rank 0 is the most urgent).
  function automatic int rank_flag(input int rank);
    case (rank)
      0:       return F_ARB;
      1:       return F_NACK;
      2:       return F_START;
      3:       return F_STOP;
      4:       return F_RX;
      default: return F_TX;
    endcase
  endfunction

  // Vector code for a rank: even numbers starting at 2.
  function automatic logic [DATA_W-1:0] rank_code(input int rank);
    return DATA_W'(2 * (rank + 1));
  endfunction
endpackage

// File: rtl/i2c_irq_flag_bank.sv
module i2c_irq_flag_bank #(
  parameter int                 N         = 6,
  parameter logic [N-1:0]       RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] q
);
  // Per flag: a set event beats any clear, and a clear beats a software write.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= RESET_VAL[i];
      else        q[i] <= set_i[i] | (~clr_i[i] & (wr_en ? wr_data[i] : q[i]));
    end
  end
endmodule

// File: rtl/i2c_irq_prio_enc.sv
module i2c_irq_prio_enc
  import i2c_irq_pkg::*;
#(
  parameter int N = NUM_FLAGS
) (
  input  logic [N-1:0]      pending,
  output logic [DATA_W-1:0] vec,
  output logic [N-1:0]      grant
);
  // Walk from the least urgent rank up, so the most urgent pending rank is written last.
  always_comb begin
    vec   = '0;
    grant = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (pending[rank_flag(r)]) begin
        vec               = rank_code(r);
        grant             = '0;
        grant[rank_flag(r)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_vector_unit.sv
module i2c_irq_vector_unit
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arb_lost,
  input  logic              ev_nack,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_rx_done,
  input  logic              ev_tx_empty,
  input  logic              rxbuf_rd,
  input  logic              txbuf_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] flags_q, en_q, set_vec, clr_vec, pending, grant;
  logic [DATA_W-1:0]    vec_code;
  logic                 vec_rd, flag_wr, en_wr;

  assign vec_rd  = reg_rd && (reg_sel == SEL_VEC);
  assign flag_wr = reg_wr && (reg_sel == SEL_FLAG);
  assign en_wr   = reg_wr && (reg_sel == SEL_EN);

  always_comb begin
    set_vec          = '0;
    set_vec[F_RX]    = ev_rx_done;
    set_vec[F_TX]    = ev_tx_empty;
    set_vec[F_START] = ev_start;
    set_vec[F_STOP]  = ev_stop;
    set_vec[F_ARB]   = ev_arb_lost;
    set_vec[F_NACK]  = ev_nack;

    clr_vec          = '0;
    clr_vec[F_RX]    = rxbuf_rd;
    clr_vec[F_TX]    = txbuf_wr;
    clr_vec[F_START] = ev_stop;
    clr_vec[F_STOP]  = ev_start;
    clr_vec[F_NACK]  = ev_start;
    clr_vec          = clr_vec | (grant & {NUM_FLAGS{vec_rd}});
  end

  i2c_irq_flag_bank #(.N(NUM_FLAGS), .RESET_VAL(FLAG_RESET)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .wr_en   (flag_wr),
    .wr_data (reg_wdata[NUM_FLAGS-1:0]),
    .q       (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata[NUM_FLAGS-1:0];
  end

  assign pending = flags_q & en_q;

  i2c_irq_prio_enc #(.N(NUM_FLAGS)) u_enc (
    .pending (pending),
    .vec     (vec_code),
    .grant   (grant)
  );

  assign irq = |pending;

  always_comb begin
    case (reg_sel)
      SEL_EN:   reg_rdata = {{PAD_W{1'b0}}, en_q};
      SEL_FLAG: reg_rdata = {{PAD_W{1'b0}}, flags_q};
      SEL_VEC:  reg_rdata = vec_code;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_irq_vector_unit_chk.sv
module i2c_irq_vector_unit_chk
  import i2c_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ev_start,
  input logic                 ev_stop,
  input logic                 ev_nack,
  input logic                 ev_rx_done,
  input logic                 ev_tx_empty,
  input logic                 txbuf_wr,
  input logic                 irq,
  input logic [NUM_FLAGS-1:0] flags_q,
  input logic [NUM_FLAGS-1:0] en_q,
  input logic [DATA_W-1:0]    vec_code
);
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> flags_q[F_RX]);                                       // R4
  AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty && txbuf_wr |=> flags_q[F_TX]);                          // R11
  AST_TX_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    txbuf_wr && !ev_tx_empty |=> !flags_q[F_TX]);                        // R5
  AST_START_CLR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start && !ev_nack |=> !flags_q[F_NACK]);                          // R6
  AST_STOP_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop && !ev_start |=> !flags_q[F_START]);                         // R7
  AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_code != '0));                                            // R9
  AST_VEC_EVEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code[0] == 1'b0 && vec_code <= 8'h0C);                           // R8
  AST_ARB_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[F_ARB] && en_q[F_ARB] |-> vec_code == 8'h02);                // R8
endmodule

bind i2c_irq_vector_unit i2c_irq_vector_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_start    (ev_start),
  .ev_stop     (ev_stop),
  .ev_nack     (ev_nack),
  .ev_rx_done  (ev_rx_done),
  .ev_tx_empty (ev_tx_empty),
  .txbuf_wr    (txbuf_wr),
  .irq         (irq),
  .flags_q     (flags_q),
  .en_q        (en_q),
  .vec_code    (vec_code)
);

// File: tb/i2c_irq_vector_unit_bench.sv
module i2c_irq_vector_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_arb_lost = 0, ev_nack = 0, ev_start = 0, ev_stop = 0;
  logic       ev_rx_done = 0, ev_tx_empty = 0, rxbuf_rd = 0, txbuf_wr = 0;
  logic [1:0] reg_sel = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  i2c_irq_vector_unit u_i2c_irq_vector_unit (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic vec_take(output logic [7:0] v);
    reg_sel = 2; reg_rd = 1; #1; v = reg_rdata; tick(); reg_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1, v); check("R3 flags after reset", v, 8'h02);
    rd(0, v); check("R2 enable after reset", v, 8'h00);
    rd(2, v); check("R9 vector with nothing enabled", v, 8'h00);
    check("R9 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    wr(0, 8'hFF); rd(0, v); check("R2 enable bits 7:6 zero", v, 8'h3F);
    wr(1, 8'hFF); rd(1, v); check("R1 R12 flag write all", v, 8'h3F);
    wr(1, 8'h00); rd(1, v); check("R12 flag write clear", v, 8'h00);
    wr(1, 8'h10); rd(2, v); check("R1 bit4 is arbitration", v, 8'h02);
    wr(1, 8'h20); rd(2, v); check("R1 bit5 is NACK", v, 8'h04);
    wr(1, 8'h00);
  endtask

  task automatic t_rx_tx();
    logic [7:0] v;
    ev_rx_done = 1; tick(); ev_rx_done = 0;
    rd(1, v); check("R4 rx sets", v, 8'h01);
    rxbuf_rd = 1; tick(); rxbuf_rd = 0;
    rd(1, v); check("R4 rx buffer read clears", v, 8'h00);
    ev_tx_empty = 1; tick(); ev_tx_empty = 0;
    rd(1, v); check("R5 tx empty sets", v, 8'h02);
    txbuf_wr = 1; tick(); txbuf_wr = 0;
    rd(1, v); check("R5 tx write clears", v, 8'h00);
  endtask

  task automatic t_start_stop();
    logic [7:0] v;
    ev_nack = 1; ev_stop = 1; tick(); ev_nack = 0; ev_stop = 0;
    rd(1, v); check("R6 setup nack+stop", v, 8'h28);
    ev_start = 1; tick(); ev_start = 0;
    rd(1, v); check("R6 start clears nack and stop", v, 8'h04);
    ev_stop = 1; tick(); ev_stop = 0;
    rd(1, v); check("R7 stop clears start", v, 8'h08);
    wr(1, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    logic [7:0] exp_codes [7] = '{8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C, 8'h00};
    wr(0, 8'h3F); wr(1, 8'h3F);
    check("R9 irq with flags pending", {7'b0, irq}, 8'h01);
    for (int k = 0; k < 7; k++) begin
      vec_take(v); check("R8 R10 drain order", v, exp_codes[k]);
    end
    rd(1, v); check("R10 all flags drained", v, 8'h00);
    check("R9 irq low after drain", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(0, 8'h01); wr(1, 8'h3F);
    rd(2, v); check("R9 only receive enabled", v, 8'h0A);
    vec_take(v);
    rd(1, v); check("R10 read clears only receive", v, 8'h3E);
    rd(2, v); check("R9 masked sources hidden", v, 8'h00);
    vec_take(v);
    rd(1, v); check("R10 zero vector read clears nothing", v, 8'h3E);
    check("R9 irq low when masked", {7'b0, irq}, 8'h00);
    wr(1, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    ev_rx_done = 1; rxbuf_rd = 1; tick(); ev_rx_done = 0; rxbuf_rd = 0;
    rd(1, v); check("R11 rx set beats read clear", v, 8'h01);
    ev_start = 1; ev_stop = 1; tick(); ev_start = 0; ev_stop = 0;
    rd(1, v); check("R11 start and stop together", v, 8'h0D);
    reg_sel = 1; reg_wdata = 8'h00; reg_wr = 1; ev_arb_lost = 1; tick();
    reg_wr = 0; ev_arb_lost = 0;
    rd(1, v); check("R11 R12 event beats write of zero", v, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_layout();
    t_rx_tx();
    t_start_stop();
    t_prio();
    t_mask();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule